// File: doc/BRIEF.md
# Password Gate and Write-Cycle Poll Controller

This block is the slave-side control logic of a serial memory that keeps three 64-bit passwords: one for reads, one for writes and one for configuration. A bus front end that handles the bit-level signalling passes it byte-level events: start condition, stop condition, and a strobe for each received byte with the byte's value. For each byte the block returns an acknowledge decision one clock later.

The host opens a transaction with a password command and then sends eight password bytes, most significant byte first. The block compares them one at a time against the stored password that the command selects. Once the eighth byte has arrived, a nonvolatile write cycle always starts. It is modelled by a counter that runs for a parameter number of clocks. The host then polls: it sends a start condition followed by the byte C0h. While the cycle is running, each poll gets a no-acknowledge. When the cycle is over, the poll is acknowledged only if the password matched, and the matching access class is then granted.

A wrong password therefore looks exactly like a device that is still busy. A write transaction that was granted and carried data also starts a write cycle when its stop condition arrives.

Top module: `pw_access_ctrl`

## Requirements
- R1: Every byte strobe is answered one clock later by a one-cycle `ack_vld_o` pulse, with `ack_o` carrying the decision (1 = acknowledge). A byte that is not preceded by a start condition is not acknowledged.
- R2: When the block is idle and not busy, a first byte of B1h (read), B2h (write) or B3h (configuration) is acknowledged as a password command. The next eight bytes are acknowledged and are compared against the selected password. The first of these bytes is compared with bits 63:56.
- R3: The clock edge that takes the eighth password byte starts a write cycle. This happens whether the password matched or not. `busy_o` is high for exactly WC_CYCLES clocks, starting after that edge.
- R4: `done_o` is high for one clock. This is the first clock in which `busy_o` is low again after a write cycle.
- R5: While `busy_o` is high, no first byte of a transaction is acknowledged, and the grant stays none.
- R6: After a write cycle that followed a matching password, a C0h poll is acknowledged. `grant_o` then takes the class that the command selected: 01 read, 10 write, 11 configuration.
- R7: After a write cycle that followed a mismatching password, every C0h poll is answered with a no-acknowledge and `grant_o` stays 00.
- R8: Once a password cycle has ended, a first byte other than C0h is not acknowledged and grants nothing. It also ends the pending password result, so the next transaction is handled normally: its first byte is acknowledged.
- R9: A start or stop condition that arrives before the eighth password byte abandons the sequence. No write cycle starts and nothing is granted.
- R10: A stop condition clears `grant_o` to 00. If the grant was write and data bytes followed it, that stop also starts a write cycle. Transactions during that cycle are refused under R5.
- R11: Reset (asynchronous, active low) clears `grant_o`, `busy_o`, `done_o` and `ack_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition seen on the bus |
| stop_i | input | 1 | Stop condition seen on the bus |
| byte_vld_i | input | 1 | A received byte is valid |
| byte_i | input | 8 | Received byte value |
| pw_read_i | input | 64 | Stored read password |
| pw_write_i | input | 64 | Stored write password |
| pw_cfg_i | input | 64 | Stored configuration password |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| grant_o | output | 2 | Granted access: 00 none, 01 read, 10 write, 11 configuration |
| busy_o | output | 1 | Write cycle running |
| done_o | output | 1 | One-cycle pulse when a write cycle ends |

## Verification
Each of the three password classes is tried with its own correct password. This shows that the command selects the right stored value and that the matching grant code is returned. Three mismatching patterns follow: a wrong last byte, a wrong first byte, and one class's password presented under another class's command. These separate a real comparison of every byte from a comparison of only one end, and they separate a per-class comparison from a shared one. Polling just after each sequence and again after the cycle ends tells busy apart from refused. The directed cases then cover the abandon paths for start and for stop, the write cycle started by a stop after granted data, the exact busy length, the done pulse, and a reset that arrives while a grant is held.

// File: rtl/pwac_pkg.sv
package pwac_pkg;

  typedef enum logic [1:0] {
    GR_NONE  = 2'b00,
    GR_READ  = 2'b01,
    GR_WRITE = 2'b10,
    GR_CFG   = 2'b11
  } grant_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_PW,
    ST_XFER,
    ST_GRANT,
    ST_DROP
  } ctl_st_e;

  localparam logic [7:0] CMD_PW_READ  = 8'hB1;
  localparam logic [7:0] CMD_PW_WRITE = 8'hB2;
  localparam logic [7:0] CMD_PW_CFG   = 8'hB3;
  localparam logic [7:0] CMD_POLL     = 8'hC0;

  // Maps a first byte to the password class it opens, GR_NONE if none.
  function automatic grant_e pw_cmd_kind(input logic [7:0] b);
    grant_e k;
    case (b)
      CMD_PW_READ:  k = GR_READ;
      CMD_PW_WRITE: k = GR_WRITE;
      CMD_PW_CFG:   k = GR_CFG;
      default:      k = GR_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pwac_wc_timer.sv
module pwac_wc_timer #(
  parameter int unsigned CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start_i) begin
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_ONE;
      done_d = (cnt_q == CNT_ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;

endmodule

// File: rtl/pwac_pw_match.sv
module pwac_pw_match
  import pwac_pkg::*;
#(
  parameter int unsigned PW_BYTES = 8,
  localparam int unsigned PW_W  = PW_BYTES * 8,
  localparam int unsigned IDX_W = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  grant_e           kind_i,
  input  logic [7:0]       byte_i,
  input  logic [PW_W-1:0]  pw_read_i,
  input  logic [PW_W-1:0]  pw_write_i,
  input  logic [PW_W-1:0]  pw_cfg_i,
  output logic             match_o
);

  logic [PW_W-1:0] sel_pw;
  logic [7:0]      lane [PW_BYTES];
  logic            match_q, match_d;

  always_comb begin
    unique case (kind_i)
      GR_READ:  sel_pw = pw_read_i;
      GR_WRITE: sel_pw = pw_write_i;
      GR_CFG:   sel_pw = pw_cfg_i;
      default:  sel_pw = '0;
    endcase
  end

  // Lane 0 is the most significant byte: the first byte on the bus.
  for (genvar g = 0; g < PW_BYTES; g++) begin : g_lane
    assign lane[g] = sel_pw[PW_W-1-8*g -: 8];
  end

  always_comb begin
    match_d = match_q;
    if (clr_i) begin
      match_d = 1'b1;
    end else if (en_i) begin
      match_d = match_q && (byte_i == lane[idx_i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else if (clr_i || en_i) begin
      match_q <= match_d;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/pw_access_ctrl.sv
module pw_access_ctrl
  import pwac_pkg::*;
#(
  parameter int unsigned PW_BYTES  = 8,
  parameter int unsigned WC_CYCLES = 1250000,
  localparam int unsigned PW_W  = PW_BYTES * 8,
  localparam int unsigned IDX_W = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic [PW_W-1:0] pw_read_i,
  input  logic [PW_W-1:0] pw_write_i,
  input  logic [PW_W-1:0] pw_cfg_i,
  output logic            ack_vld_o,
  output logic            ack_o,
  output logic [1:0]      grant_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PW_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctl_st_e          st_q, st_d;
  grant_e           kind_q, kind_d;
  grant_e           grant_q, grant_d;
  grant_e           cmd_kind;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, pend_d;
  logic             wdirty_q, wdirty_d;
  logic             ack_q, ack_d;
  logic             ackv_q, ackv_d;
  logic             wc_start, cmp_clr, cmp_en;
  logic             pw_ok, wc_busy, wc_done;

  assign cmd_kind = pw_cmd_kind(byte_i);

  pwac_wc_timer #(
    .CYCLES (WC_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (wc_start),
    .busy_o  (wc_busy),
    .done_o  (wc_done)
  );

  pwac_pw_match #(
    .PW_BYTES (PW_BYTES)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .clr_i      (cmp_clr),
    .en_i       (cmp_en),
    .idx_i      (idx_q),
    .kind_i     (kind_q),
    .byte_i     (byte_i),
    .pw_read_i  (pw_read_i),
    .pw_write_i (pw_write_i),
    .pw_cfg_i   (pw_cfg_i),
    .match_o    (pw_ok)
  );

  // Next-state logic. Priority: start, then stop, then byte.
  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    grant_d  = grant_q;
    idx_d    = idx_q;
    pend_d   = pend_q;
    wdirty_d = wdirty_q;
    ack_d    = 1'b0;
    ackv_d   = 1'b0;
    wc_start = 1'b0;
    cmp_clr  = 1'b0;
    cmp_en   = 1'b0;

    if (start_i) begin
      st_d  = ST_CMD;
      idx_d = '0;
    end else if (stop_i) begin
      st_d = ST_IDLE;
      if ((grant_q == GR_WRITE) && wdirty_q) begin
        wc_start = 1'b1;
      end
      grant_d  = GR_NONE;
      wdirty_d = 1'b0;
    end else if (byte_vld_i) begin
      ackv_d = 1'b1;
      unique case (st_q)
        ST_CMD: begin
          if (wc_busy) begin
            st_d = ST_DROP;
          end else if (pend_q) begin
            st_d = ST_DROP;
            if (byte_i == CMD_POLL) begin
              if (pw_ok) begin
                ack_d   = 1'b1;
                grant_d = kind_q;
                pend_d  = 1'b0;
                st_d    = ST_GRANT;
              end
            end else begin
              pend_d = 1'b0;
            end
          end else if (cmd_kind != GR_NONE) begin
            ack_d   = 1'b1;
            kind_d  = cmd_kind;
            idx_d   = '0;
            cmp_clr = 1'b1;
            st_d    = ST_PW;
          end else begin
            ack_d = 1'b1;
            st_d  = ST_XFER;
          end
        end
        ST_PW: begin
          ack_d  = 1'b1;
          cmp_en = 1'b1;
          if (idx_q == IDX_LAST) begin
            wc_start = 1'b1;
            pend_d   = 1'b1;
            st_d     = ST_DROP;
          end else begin
            idx_d = idx_q + IDX_ONE;
          end
        end
        ST_GRANT: begin
          ack_d = 1'b1;
          if (grant_q == GR_WRITE) begin
            wdirty_d = 1'b1;
          end
        end
        ST_XFER: begin
          ack_d = 1'b1;
        end
        default: begin
          ack_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q     <= ST_IDLE;
      kind_q   <= GR_NONE;
      grant_q  <= GR_NONE;
      idx_q    <= '0;
      pend_q   <= 1'b0;
      wdirty_q <= 1'b0;
      ack_q    <= 1'b0;
      ackv_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      grant_q  <= grant_d;
      idx_q    <= idx_d;
      pend_q   <= pend_d;
      wdirty_q <= wdirty_d;
      ack_q    <= ack_d;
      ackv_q   <= ackv_d;
    end
  end

  assign ack_vld_o = ackv_q;
  assign ack_o     = ack_q;
  assign grant_o   = grant_q;
  assign busy_o    = wc_busy;
  assign done_o    = wc_done;

endmodule

// File: rtl/pwac_checker.sv
module pwac_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic       ack_vld_o,
  input logic       ack_o,
  input logic [1:0] grant_o,
  input logic       busy_o,
  input logic       done_o
);

  assert_byte_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i) |=> ack_vld_o);

  assert_answer_has_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(byte_vld_i));

  assert_cycle_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(byte_vld_i) || $past(stop_i)));

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_no_ack_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld_o && ack_o) |-> !$past(busy_o));

  assert_grant_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != 2'b00) && ($past(grant_o) == 2'b00)) |-> (ack_vld_o && ack_o && !$past(busy_o)));

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_i) && !$past(start_i)) |-> (grant_o == 2'b00));

endmodule

bind pw_access_ctrl pwac_checker u_pwac_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .byte_vld_i (byte_vld_i),
  .ack_vld_o  (ack_vld_o),
  .ack_o      (ack_o),
  .grant_o    (grant_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_pw_access_ctrl.sv
`timescale 1ns/1ps
module test_pw_access_ctrl;

  localparam int unsigned WC = 20;
  localparam int unsigned NV = 6;

  localparam logic [63:0] PW_RD  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PW_WR  = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] PW_CF  = 64'h1122_3344_5566_7788;

  // Vector table: command, presented password, expected grant after poll.
  localparam logic [7:0]  V_CMD [NV] = '{8'hB1, 8'hB2, 8'hB3, 8'hB1, 8'hB2, 8'hB3};
  localparam logic [63:0] V_PW  [NV] = '{64'h0123_4567_89AB_CDEF,
                                         64'hFEDC_BA98_7654_3210,
                                         64'h1122_3344_5566_7788,
                                         64'h0123_4567_89AB_CDEE,
                                         64'h7EDC_BA98_7654_3210,
                                         64'h0123_4567_89AB_CDEF};
  localparam logic [1:0]  V_GR  [NV] = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b00, 2'b00};

  logic        clk;
  logic        rst_n;
  logic        start_i, stop_i, byte_vld_i;
  logic [7:0]  byte_i;
  logic        ack_vld_o, ack_o, busy_o, done_o;
  logic [1:0]  grant_o;

  int checks;
  int errors;

  pw_access_ctrl #(
    .PW_BYTES  (8),
    .WC_CYCLES (WC)
  ) i_pw_access_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .pw_read_i  (PW_RD),
    .pw_write_i (PW_WR),
    .pw_cfg_i   (PW_CF),
    .ack_vld_o  (ack_vld_o),
    .ack_o      (ack_o),
    .grant_o    (grant_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // Drives one byte; returns the acknowledge seen one clock later.
  task automatic send_byte(input logic [7:0] b, output logic a);
    @(negedge clk);
    byte_vld_i = 1'b1;
    byte_i     = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
    a = ack_vld_o ? ack_o : 1'bx;
  endtask

  task automatic pw_seq(input logic [7:0] cmd, input logic [63:0] pw, input int nbytes);
    logic a;
    send_start();
    send_byte(cmd, a);
    chk("R2 password command ack", a, 1'b1);
    for (int k = 0; k < nbytes; k++) begin
      send_byte(pw[63-8*k -: 8], a);
      if (k == 0) chk("R2 password byte ack", a, 1'b1);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic a;
    int   nb, nd;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    start_i = 1'b0; stop_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    repeat (4) @(negedge clk);
    chk("R11 grant in reset", grant_o, 2'b00);
    chk("R11 busy in reset", busy_o, 1'b0);
    chk("R11 ack_vld in reset", ack_vld_o, 1'b0);
    chk("R11 done in reset", done_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: a byte with no start condition is refused.
    send_byte(8'h55, a);
    chk("R1 byte without start", a, 1'b0);

    // Table walk over password classes and patterns.
    for (int i = 0; i < NV; i++) begin
      pw_seq(V_CMD[i], V_PW[i], 8);
      chk("R3 cycle starts after 8th byte", busy_o, 1'b1);
      send_start();
      send_byte(8'hC0, a);
      chk("R5 poll while busy", a, 1'b0);
      chk("R5 no grant while busy", grant_o, 2'b00);
      send_stop();
      wait_idle();
      send_start();
      send_byte(8'hC0, a);
      chk((V_GR[i] != 0) ? "R6 poll ack on match" : "R7 poll nack on mismatch",
          a, (V_GR[i] != 2'b00));
      chk((V_GR[i] != 0) ? "R6 grant class" : "R7 no grant", grant_o, V_GR[i]);
      if (V_GR[i] == 2'b00) begin
        send_stop();
        send_start();
        send_byte(8'hC0, a);
        chk("R7 repeated poll nack", a, 1'b0);
        send_stop();
        send_start();
        send_byte(8'h00, a);
        chk("R8 non-poll byte nack", a, 1'b0);
        chk("R8 no grant", grant_o, 2'b00);
        send_stop();
        send_start();
        send_byte(8'h00, a);
        chk("R8 normal after pending ends", a, 1'b1);
        send_stop();
      end else begin
        send_stop();
        chk("R10 stop clears grant", grant_o, 2'b00);
      end
    end

    // R3/R4: exact busy length and single done pulse.
    pw_seq(8'hB1, PW_RD, 8);
    nb = 0; nd = 0;
    while (busy_o && nb < 100) begin
      nb++;
      if (done_o) nd++;
      @(negedge clk);
    end
    chk("R3 busy length", nb, WC);
    chk("R4 done at busy end", done_o, 1'b1);
    chk("R4 no done during busy", nd, 0);
    @(negedge clk);
    chk("R4 done one cycle", done_o, 1'b0);
    send_start();
    send_byte(8'hC0, a);
    chk("R6 read grant", grant_o, 2'b01);
    send_stop();

    // R9: start abandons a partial sequence.
    pw_seq(8'hB1, PW_RD, 3);
    send_start();
    chk("R9 no cycle after start abandon", busy_o, 1'b0);
    send_byte(8'hC0, a);
    chk("R9 byte after abandon is ordinary", a, 1'b1);
    chk("R9 no grant after abandon", grant_o, 2'b00);
    send_stop();
    // R9: stop abandons a partial sequence.
    pw_seq(8'hB2, PW_WR, 5);
    send_stop();
    chk("R9 no cycle after stop abandon", busy_o, 1'b0);
    send_start();
    send_byte(8'hC0, a);
    chk("R9 no grant after stop abandon", grant_o, 2'b00);
    send_stop();

    // R10: granted write with data starts a cycle on stop.
    pw_seq(8'hB2, PW_WR, 8);
    wait_idle();
    send_start();
    send_byte(8'hC0, a);
    chk("R10 write grant", grant_o, 2'b10);
    send_byte(8'hA5, a);
    chk("R10 data byte ack", a, 1'b1);
    send_stop();
    chk("R10 stop clears write grant", grant_o, 2'b00);
    chk("R10 stop starts cycle", busy_o, 1'b1);
    send_start();
    send_byte(8'h33, a);
    chk("R10 command refused during cycle", a, 1'b0);
    send_stop();
    wait_idle();
    send_start();
    send_byte(8'h33, a);
    chk("R10 command accepted after cycle", a, 1'b1);
    send_stop();

    // R11: reset while a grant is held.
    pw_seq(8'hB3, PW_CF, 8);
    wait_idle();
    send_start();
    send_byte(8'hC0, a);
    chk("R6 config grant", grant_o, 2'b11);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears grant", grant_o, 2'b00);
    chk("R11 reset clears busy", busy_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule